// File: doc/BRIEF.md
# MSB-First Serial Byte Receiver with Overrun Detection

This block is the receive half of an asynchronous serial port. It watches a single serial input line, recognises a start bit, and samples each following bit in the middle of its bit period. A sampling tick input sets the rate, with sixteen ticks making one bit. Eight data bits arrive most-significant first and are collected in a shift register. An optional parity bit follows, and then a stop bit. When the stop bit is sampled, the byte moves into a one-byte holding buffer.

Software sees the holding buffer through a valid/ready read port. `rd_valid` stays high while the buffered byte has not yet been taken. One cycle with `rd_valid` and `rd_ready` both high takes the byte. While `rd_ready` is low the byte and `rd_valid` are held, and the receiver never waits on the reader. If a frame completes while the previous byte is still untaken and the full flag is set, the new byte is dropped and an overrun is reported.

Three sticky flags are exposed: buffer full, parity error and overrun. Each one is cleared by a one-cycle clear pulse. A busy flag shows that a frame is being shifted in. An interrupt line combines the three sticky flags.

Top module: `msb_uart_rx`

## Requirements
- R1: After reset, `busy`, `full`, `perr`, `ovr`, `irq` and `rd_valid` are all 0.
- R2: A low level on `rxd` starts a frame only if `rxd` is still low at the middle of the start bit. A low pulse shorter than half a bit sets neither `busy` nor `full` and delivers no byte.
- R3: Each bit lasts 16 `tick` pulses and is sampled at its middle. The first data bit after the start bit becomes bit 7 of `rd_data`, and the eighth becomes bit 0.
- R4: `busy` is 1 from the validated start bit until the cycle in which the stop bit is sampled, and is 0 after that.
- R5: When the stop bit is sampled and no overrun occurs, the byte appears on `rd_data`, and `full` and `rd_valid` become 1. `rd_data` changes at no other time.
- R6: When `par_en` is 1, the bit after the eighth data bit is a parity bit. With `par_odd`=0 the data bits and the parity bit together must hold an even number of ones; with `par_odd`=1, an odd number. A mismatch sets `perr` when the byte is loaded. When `par_en` is 0 there is no parity bit and `perr` is not set.
- R7: A 1 on `clr_full`, `clr_perr` or `clr_ovr` clears only that flag. A set of a flag in the same cycle as its clear leaves the flag at 1.
- R8: If a frame completes while `full` is 1 and the buffered byte has not been taken, `ovr` becomes 1. The new byte is discarded, and `rd_data`, `rd_valid` and `full` keep their values.
- R9: A cycle with `rd_valid` and `rd_ready` high takes the byte and drops `rd_valid`. A take in the same cycle as a frame completion counts before the load: no overrun, and the new byte is loaded.
- R10: `irq` is 1 exactly when at least one of `full`, `perr` or `ovr` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sampling tick, 16 per bit |
| rxd | input | 1 | Serial input, idle high |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rd_data | output | 8 | Buffered byte |
| rd_valid | output | 1 | Buffered byte not yet taken |
| rd_ready | input | 1 | Reader takes the byte this cycle |
| clr_full | input | 1 | Write-1 clear of `full` |
| clr_perr | input | 1 | Write-1 clear of `perr` |
| clr_ovr | input | 1 | Write-1 clear of `ovr` |
| busy | output | 1 | Frame being shifted in |
| full | output | 1 | Sticky buffer-full flag |
| perr | output | 1 | Sticky parity error flag |
| ovr | output | 1 | Sticky overrun flag |
| irq | output | 1 | Receive interrupt |

## Verification
Two pairs of events can land on the same clock edge: a frame completing as the reader takes the previous byte, and a byte load setting `full` as software pulses `clr_full`.

To provoke each pair, the bench counts clock cycles from the start edge it drives, pulsing `rd_ready` or `clr_full` so that it lands on the edge where the stop bit is sampled. With the take, the expected result is no overrun and the new byte on `rd_data`. With the clear, `full` must stay at 1.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '1;
        else        q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] byte_out,
  output logic              par_bad
);
  localparam int CW  = $clog2(OVS);
  localparam int NBW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0]  LAST = CW'(OVS - 1);
  localparam logic [CW-1:0]  MID  = CW'(OVS / 2 - 1);
  localparam logic [NBW-1:0] NLST = NBW'(DATA_W - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [NBW-1:0]    nbit;
  logic [DATA_W-1:0] shreg;
  logic              pbit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      cnt   <= '0;
      nbit  <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
    end else if (tick) begin
      case (state)
        RX_IDLE: begin
          if (!rxd) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end
        RX_START: begin
          if (cnt == MID) begin
            cnt   <= '0;
            nbit  <= '0;
            state <= rxd ? RX_IDLE : RX_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            shreg <= {shreg[DATA_W-2:0], rxd};
            if (nbit == NLST) state <= par_en ? RX_PAR : RX_STOP;
            else              nbit  <= nbit + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_PAR: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            pbit  <= rxd;
            state <= RX_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= RX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign busy     = (state == RX_DATA) || (state == RX_PAR) || (state == RX_STOP);
  assign done     = tick && (state == RX_STOP) && (cnt == LAST);
  assign byte_out = shreg;
  assign par_bad  = par_en && ((^{shreg, pbit}) != par_odd);
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              par_bad,
  input  logic              rd_ready,
  input  logic              clr_full,
  input  logic              clr_perr,
  input  logic              clr_ovr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              full,
  output logic              perr,
  output logic              ovr
);
  logic take;
  logic ovr_ev;
  logic load;

  assign take   = rd_valid && rd_ready;
  assign ovr_ev = done && full && rd_valid && !take;
  assign load   = done && !ovr_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      full     <= 1'b0;
      perr     <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      if (load) rd_data <= byte_in;
      rd_valid <= (rd_valid && !take) || load;
      full     <= (full && !clr_full) || load;
      perr     <= (perr && !clr_perr) || (load && par_bad);
      ovr      <= (ovr && !clr_ovr) || ovr_ev;
    end
  end
endmodule

// File: rtl/msb_uart_rx.sv
module msb_uart_rx #(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              par_en,
  input  logic              par_odd,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic              clr_full,
  input  logic              clr_perr,
  input  logic              clr_ovr,
  output logic              busy,
  output logic              full,
  output logic              perr,
  output logic              ovr,
  output logic              irq
);
  logic              rx_s;
  logic              done;
  logic [DATA_W-1:0] shifted;
  logic              par_bad;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
  );

  rx_framer #(.OVS(OVS), .DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rx_s),
    .par_en(par_en), .par_odd(par_odd), .busy(busy),
    .done(done), .byte_out(shifted), .par_bad(par_bad)
  );

  rx_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .done(done), .byte_in(shifted),
    .par_bad(par_bad), .rd_ready(rd_ready), .clr_full(clr_full),
    .clr_perr(clr_perr), .clr_ovr(clr_ovr), .rd_data(rd_data),
    .rd_valid(rd_valid), .full(full), .perr(perr), .ovr(ovr)
  );

  assign irq = full || perr || ovr;
endmodule

// File: rtl/rx_checker.sv
module rx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              full,
  input logic              perr,
  input logic              ovr,
  input logic              irq,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data
);
  assert_busy_ends_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> full);

  assert_idle_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> $stable(rd_data));

  assert_keep_on_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> ($stable(rd_data) && rd_valid && full));

  assert_hold_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  assert_irq_on_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(full) || $rose(perr) || $rose(ovr)) |-> irq);
endmodule

bind msb_uart_rx rx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .full(full), .perr(perr),
  .ovr(ovr), .irq(irq), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data)
);

// File: tb/sim_msb_uart_rx.sv
`timescale 1ns/1ps
module sim_msb_uart_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       rxd = 1'b1;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic       clr_full = 1'b0;
  logic       clr_perr = 1'b0;
  logic       clr_ovr = 1'b0;
  logic       busy, full, perr, ovr, irq;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  msb_uart_rx u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .par_en(par_en),
    .par_odd(par_odd), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .clr_full(clr_full), .clr_perr(clr_perr),
    .clr_ovr(clr_ovr), .busy(busy), .full(full), .perr(perr),
    .ovr(ovr), .irq(irq)
  );

  // {data[7:0], parity enable, odd select, send wrong parity}
  localparam logic [10:0] VEC [0:5] = '{
    {8'hA5, 1'b0, 1'b0, 1'b0},
    {8'h01, 1'b1, 1'b0, 1'b0},
    {8'h80, 1'b1, 1'b1, 1'b0},
    {8'h3C, 1'b1, 1'b0, 1'b1},
    {8'hFF, 1'b1, 1'b1, 1'b1},
    {8'h6E, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ev: bit0 pulses rd_ready, bit1 pulses clr_full on the stop-sample edge
  task automatic send_frame(input logic [7:0] d, input logic pe, input logic po,
                            input logic flip, input logic [1:0] ev);
    logic [10:0] bits;
    int nb;
    int k;
    nb = pe ? 11 : 10;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[1+i] = d[7-i];
    bits[9] = pe ? ((^d) ^ po ^ flip) : 1'b1;
    bits[10] = 1'b1;
    par_en = pe;
    par_odd = po;
    k = 0;
    for (int b = 0; b < nb; b++) begin
      for (int c = 0; c < 16; c++) begin
        rxd = bits[b];
        rd_ready = (k == nb*16 - 6) && ev[0];
        clr_full = (k == nb*16 - 6) && ev[1];
        if (k == 80) begin
          #1;
          chk("R4 busy mid-frame", {7'b0, busy}, 8'd1);
        end
        @(negedge clk);
        k++;
      end
    end
    rd_ready = 1'b0;
    clr_full = 1'b0;
    rxd = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic take_byte();
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic clear_all();
    clr_full = 1'b1; clr_perr = 1'b1; clr_ovr = 1'b1;
    @(negedge clk);
    clr_full = 1'b0; clr_perr = 1'b0; clr_ovr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 busy", {7'b0, busy}, 8'd0);
    chk("R1 full", {7'b0, full}, 8'd0);
    chk("R1 perr", {7'b0, perr}, 8'd0);
    chk("R1 ovr", {7'b0, ovr}, 8'd0);
    chk("R1 irq", {7'b0, irq}, 8'd0);
    chk("R1 rd_valid", {7'b0, rd_valid}, 8'd0);
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      logic [10:0] e;
      e = VEC[v];
      send_frame(e[10:3], e[2], e[1], e[0], 2'b00);
      #1;
      chk("R3 data", rd_data, e[10:3]);
      chk("R5 full", {7'b0, full}, 8'd1);
      chk("R5 rd_valid", {7'b0, rd_valid}, 8'd1);
      chk("R6 perr", {7'b0, perr}, {7'b0, e[2] & e[0]});
      chk("R4 busy after", {7'b0, busy}, 8'd0);
      chk("R10 irq set", {7'b0, irq}, 8'd1);
      @(negedge clk);
      take_byte();
      #1;
      chk("R9 taken", {7'b0, rd_valid}, 8'd0);
      @(negedge clk);
      clear_all();
      #1;
      chk("R7 full cleared", {7'b0, full}, 8'd0);
      chk("R7 perr cleared", {7'b0, perr}, 8'd0);
      chk("R10 irq clear", {7'b0, irq}, 8'd0);
      @(negedge clk);
    end

    // R2: short glitch is not a start bit
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    #1;
    chk("R2 glitch busy", {7'b0, busy}, 8'd0);
    chk("R2 glitch full", {7'b0, full}, 8'd0);
    chk("R2 glitch valid", {7'b0, rd_valid}, 8'd0);
    @(negedge clk);

    // R8: overrun keeps the old byte
    send_frame(8'h12, 1'b0, 1'b0, 1'b0, 2'b00);
    send_frame(8'h34, 1'b0, 1'b0, 1'b0, 2'b00);
    #1;
    chk("R8 ovr", {7'b0, ovr}, 8'd1);
    chk("R8 old data", rd_data, 8'h12);
    chk("R8 full kept", {7'b0, full}, 8'd1);
    chk("R10 irq ovr", {7'b0, irq}, 8'd1);
    @(negedge clk);
    take_byte();
    clr_ovr = 1'b1;
    @(negedge clk);
    clr_ovr = 1'b0;
    #1;
    chk("R7 ovr cleared", {7'b0, ovr}, 8'd0);
    chk("R7 full untouched", {7'b0, full}, 8'd1);
    @(negedge clk);
    clear_all();

    // R9: byte taken before next frame, no overrun
    send_frame(8'h55, 1'b0, 1'b0, 1'b0, 2'b00);
    take_byte();
    send_frame(8'h66, 1'b0, 1'b0, 1'b0, 2'b00);
    #1;
    chk("R9 no ovr", {7'b0, ovr}, 8'd0);
    chk("R9 new data", rd_data, 8'h66);
    @(negedge clk);
    take_byte();
    clear_all();

    // R9: take on the completion edge
    send_frame(8'h77, 1'b0, 1'b0, 1'b0, 2'b00);
    send_frame(8'h88, 1'b0, 1'b0, 1'b0, 2'b01);
    #1;
    chk("R9 same-edge ovr", {7'b0, ovr}, 8'd0);
    chk("R9 same-edge data", rd_data, 8'h88);
    chk("R9 same-edge valid", {7'b0, rd_valid}, 8'd1);
    @(negedge clk);
    take_byte();
    clear_all();

    // R7: clear of full on the load edge loses to the set
    send_frame(8'h99, 1'b0, 1'b0, 1'b0, 2'b00);
    take_byte();
    send_frame(8'hC3, 1'b0, 1'b0, 1'b0, 2'b10);
    #1;
    chk("R7 set wins", {7'b0, full}, 8'd1);
    chk("R5 data loaded", rd_data, 8'hC3);
    @(negedge clk);
    clr_perr = 1'b1;
    @(negedge clk);
    clr_perr = 1'b0;
    #1;
    chk("R7 other clear", {7'b0, full}, 8'd1);
    @(negedge clk);
    take_byte();
    clear_all();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule